// File: doc/BRIEF.md
# Overlapped register window file

This block is the general-purpose register file of a processor that gives every procedure its own window onto a larger physical file. A global bank is visible without change from every window. The other registers form a ring of windows. The upper shared group of one window is, physically, the lower shared group of the next window. A caller leaves its arguments in its upper shared registers, and after the call the callee finds them in its lower shared registers. No data is copied.

The instruction stream addresses registers by logical number on two combinational read ports and one synchronous write port. Call and return strobes advance or retreat a current window pointer on the clock edge. A resident-window counter flags overflow when a call finds every window in use. It flags underflow when a return finds only one window in use. Spilling and refilling is left to software, and the pointer moves regardless.

With the default parameters the file has 10 globals and four windows. Each window has 10 locals and 6 shared registers, so the file holds 74 physical registers and each window shows 32 logical ones.

Top module: `orw_regfile`

## Requirements
- R1: After reset every physical register reads 0, the window pointer is 0, one window counts as resident and both flags are low.
- R2: Logical numbers 0 to 9 reach physical registers 0 to 9 whatever the window pointer is.
- R3: In window p, a logical number n from 10 to 31 reaches physical register 10 + ((16·p + n − 10) mod 64). Logical 10–15 are the lower shared group, 16–25 the locals and 26–31 the upper shared group.
- R4: A value written to logical 26+k (k = 0..5) in window p reads back at logical 10+k in window p+1.
- R5: The windows form a ring: the upper shared group of window 3 is the lower shared group of window 0, which is physical 10 to 15.
- R6: A call alone sets the pointer to (p+1) mod 4 at the next edge. A return alone sets it to (p−1) mod 4.
- R7: A call and a return in the same cycle leave the pointer and the resident count unchanged and raise neither flag.
- R8: Reads are combinational and use the pointer in force before the edge. A write lands at the edge and is mapped through that same pre-edge pointer, including when a call or return happens in the same cycle.
- R9: The overflow flag is high, in the same cycle, when a call (without return) occurs while four windows are resident. The pointer still advances and the count stays at four.
- R10: The underflow flag is high, in the same cycle, when a return (without call) occurs while one window is resident. The pointer still retreats and the count stays at one.
- R11: The two read ports are independent and return the same value when given the same logical number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 5 | Logical register number for read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_idx | input | 5 | Logical register number for read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Logical register number to write |
| wr_data | input | 32 | Write data |
| call_req | input | 1 | Procedure call strobe, advances the window |
| ret_req | input | 1 | Procedure return strobe, retreats the window |
| win_ptr | output | 2 | Current window pointer |
| spill_flag | output | 1 | Overflow: call with every window resident |
| fill_flag | output | 1 | Underflow: return with one window resident |

## Verification
A write and a window move can fall in the same cycle. The write must then land through the old window, so a caller can store its last argument on the same edge as the call. The bench provokes this by writing an upper shared register with the call strobe raised. On the next cycle it reads the matching lower shared register in the new window. Random traffic also mixes writes with calls, returns and simultaneous call-plus-return. Every read is judged against a bench model that applies the write with the pre-edge pointer before it moves the pointer.

// File: rtl/orw_pkg.sv
package orw_pkg;

  // Direction the window pointer takes at the next edge.
  typedef enum logic [1:0] {
    WIN_HOLD    = 2'd0,
    WIN_ADVANCE = 2'd1,
    WIN_RETREAT = 2'd2
  } win_move_e;

  // Physical register behind a logical number in a given window.
  function automatic int unsigned phys_index(
    input int unsigned ptr,
    input int unsigned lidx,
    input int unsigned nglob,
    input int unsigned stride,
    input int unsigned nwin
  );
    if (lidx < nglob) return lidx;
    return nglob + ((stride * ptr + lidx - nglob) % (stride * nwin));
  endfunction

  // Next pointer value on a move, wrapping around the ring.
  function automatic int unsigned ring_step(
    input int unsigned ptr,
    input win_move_e   mv,
    input int unsigned nwin
  );
    case (mv)
      WIN_ADVANCE: return (ptr == nwin - 1) ? 0 : ptr + 1;
      WIN_RETREAT: return (ptr == 0) ? nwin - 1 : ptr - 1;
      default:     return ptr;
    endcase
  endfunction

endpackage

// File: rtl/orw_window_ctrl.sv
module orw_window_ctrl
  import orw_pkg::*;
#(
  parameter int NWIN = 4,
  parameter int PTRW = 2,
  parameter int CNTW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            call_req,
  input  logic            ret_req,
  output logic [PTRW-1:0] ptr,
  output logic [CNTW-1:0] resident,
  output win_move_e       move,
  output logic            spill,
  output logic            fill
);

  localparam logic [CNTW-1:0] FULL = CNTW'(NWIN);
  localparam logic [CNTW-1:0] ONE  = CNTW'(1);

  logic at_full;
  logic at_one;

  always_comb begin
    if (call_req && !ret_req)      move = WIN_ADVANCE;
    else if (ret_req && !call_req) move = WIN_RETREAT;
    else                           move = WIN_HOLD;
  end

  assign at_full = (resident == FULL);
  assign at_one  = (resident == ONE);
  assign spill   = (move == WIN_ADVANCE) && at_full;
  assign fill    = (move == WIN_RETREAT) && at_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      resident <= ONE;
    end else begin
      ptr <= PTRW'(ring_step(int'(ptr), move, NWIN));
      if (move == WIN_ADVANCE && !at_full)     resident <= resident + ONE;
      else if (move == WIN_RETREAT && !at_one) resident <= resident - ONE;
    end
  end

endmodule

// File: rtl/orw_addr_map.sv
module orw_addr_map
  import orw_pkg::*;
#(
  parameter int NGLOB  = 10,
  parameter int STRIDE = 16,
  parameter int NWIN   = 4,
  parameter int LW     = 5,
  parameter int PTRW   = 2,
  parameter int PW     = 7
) (
  input  logic [PTRW-1:0] ptr,
  input  logic [LW-1:0]   lidx,
  output logic [PW-1:0]   pidx
);

  always_comb begin
    pidx = PW'(phys_index(int'(ptr), int'(lidx), NGLOB, STRIDE, NWIN));
  end

endmodule

// File: rtl/orw_phys_bank.sv
module orw_phys_bank #(
  parameter int NPHYS = 74,
  parameter int DW    = 32,
  parameter int PW    = 7,
  parameter int NRD   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [PW-1:0]       waddr,
  input  logic [DW-1:0]       wdata,
  input  logic [NRD*PW-1:0]   raddr,
  output logic [NRD*DW-1:0]   rdata
);

  logic [DW-1:0] regs [NPHYS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
    end else if (we && (int'(waddr) < NPHYS)) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    logic [PW-1:0] a;
    assign a = raddr[g*PW +: PW];
    assign rdata[g*DW +: DW] = (int'(a) < NPHYS) ? regs[a] : '0;
  end

endmodule

// File: rtl/orw_regfile.sv
module orw_regfile
  import orw_pkg::*;
#(
  parameter int NGLOB = 10,
  parameter int NLOC  = 10,
  parameter int NSHR  = 6,
  parameter int NWIN  = 4,
  parameter int DW    = 32,
  localparam int NLOG  = NGLOB + NLOC + 2 * NSHR,
  localparam int LW    = $clog2(NLOG),
  localparam int PTRW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   rd_a_idx,
  output logic [DW-1:0]   rd_a_data,
  input  logic [LW-1:0]   rd_b_idx,
  output logic [DW-1:0]   rd_b_data,
  input  logic            wr_en,
  input  logic [LW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            call_req,
  input  logic            ret_req,
  output logic [PTRW-1:0] win_ptr,
  output logic            spill_flag,
  output logic            fill_flag
);

  localparam int STRIDE = NLOC + NSHR;
  localparam int NPHYS  = STRIDE * NWIN + NGLOB;
  localparam int PW     = $clog2(NPHYS);
  localparam int CNTW   = $clog2(NWIN + 1);
  localparam int NMAP   = 3;   // read A, read B, write

  // Named internal events, visible to the bound checker.
  logic [CNTW-1:0] resident;
  win_move_e       move;
  logic [PW-1:0]   rd_a_phys;
  logic [PW-1:0]   rd_b_phys;
  logic [PW-1:0]   wr_phys;

  logic [NMAP*LW-1:0] map_in;
  logic [NMAP*PW-1:0] map_out;
  logic [2*DW-1:0]    rd_bus;

  orw_window_ctrl #(
    .NWIN(NWIN), .PTRW(PTRW), .CNTW(CNTW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .call_req (call_req),
    .ret_req  (ret_req),
    .ptr      (win_ptr),
    .resident (resident),
    .move     (move),
    .spill    (spill_flag),
    .fill     (fill_flag)
  );

  assign map_in = {wr_idx, rd_b_idx, rd_a_idx};

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    orw_addr_map #(
      .NGLOB(NGLOB), .STRIDE(STRIDE), .NWIN(NWIN),
      .LW(LW), .PTRW(PTRW), .PW(PW)
    ) u_map (
      .ptr  (win_ptr),
      .lidx (map_in[g*LW +: LW]),
      .pidx (map_out[g*PW +: PW])
    );
  end

  assign rd_a_phys = map_out[0 +: PW];
  assign rd_b_phys = map_out[PW +: PW];
  assign wr_phys   = map_out[2*PW +: PW];

  orw_phys_bank #(
    .NPHYS(NPHYS), .DW(DW), .PW(PW), .NRD(2)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .waddr (wr_phys),
    .wdata (wr_data),
    .raddr ({rd_b_phys, rd_a_phys}),
    .rdata (rd_bus)
  );

  assign rd_a_data = rd_bus[0 +: DW];
  assign rd_b_data = rd_bus[DW +: DW];

endmodule

// File: rtl/orw_regfile_chk.sv
module orw_regfile_chk #(
  parameter int NWIN  = 4,
  parameter int NPHYS = 74,
  parameter int PTRW  = 2,
  parameter int CNTW  = 3,
  parameter int PW    = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            call_req,
  input logic            ret_req,
  input logic [PTRW-1:0] win_ptr,
  input logic [CNTW-1:0] resident,
  input logic            spill_flag,
  input logic            fill_flag,
  input logic [PW-1:0]   rd_a_phys,
  input logic [PW-1:0]   rd_b_phys,
  input logic [PW-1:0]   wr_phys
);

  // R6
  ptr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && !ret_req) |=> int'(win_ptr) == ((int'($past(win_ptr)) + 1) % NWIN));

  // R6
  ptr_retreat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !call_req) |=> int'(win_ptr) == ((int'($past(win_ptr)) + NWIN - 1) % NWIN));

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req == ret_req) |=> ($stable(win_ptr) && $stable(resident)));

  // R9
  spill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spill_flag |-> (call_req && !ret_req && int'(resident) == NWIN));

  // R9
  spill_keep_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spill_flag |=> int'(resident) == NWIN);

  // R10
  fill_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_flag |-> (ret_req && !call_req && int'(resident) == 1));

  // R10
  fill_keep_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_flag |=> int'(resident) == 1);

  // R1
  resident_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(resident) >= 1) && (int'(resident) <= NWIN));

  // R3
  phys_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_a_phys) < NPHYS) && (int'(rd_b_phys) < NPHYS) && (int'(wr_phys) < NPHYS));

  // R7
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(spill_flag && fill_flag));

endmodule

bind orw_regfile orw_regfile_chk #(
  .NWIN(NWIN), .NPHYS(NPHYS), .PTRW(PTRW), .CNTW(CNTW), .PW(PW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .call_req   (call_req),
  .ret_req    (ret_req),
  .win_ptr    (win_ptr),
  .resident   (resident),
  .spill_flag (spill_flag),
  .fill_flag  (fill_flag),
  .rd_a_phys  (rd_a_phys),
  .rd_b_phys  (rd_b_phys),
  .wr_phys    (wr_phys)
);

// File: tb/orw_regfile_bench.sv
module orw_regfile_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NPH = 74;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, call_req = 1'b0, ret_req = 1'b0;
  logic [1:0]  win_ptr;
  logic        spill_flag, fill_flag;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] mdl [NPH];
  int mptr = 0;
  int mres = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  orw_regfile u_orw_regfile (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .call_req(call_req), .ret_req(ret_req),
    .win_ptr(win_ptr), .spill_flag(spill_flag), .fill_flag(fill_flag)
  );

  // Window base plus offset, folded back into the windowed range.
  function automatic int bmap(int p, int l);
    int off;
    if (l < 10) return l;
    off = p * 16 + (l - 10);
    while (off >= 64) off -= 64;
    return 10 + off;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a negedge: drive, compare combinational outputs, take the edge, update model.
  task automatic step(logic c, logic r, logic we, int wi, logic [31:0] wd,
                      int ra, int rb, string tag);
    bit exp_sp, exp_fl;
    call_req = c; ret_req = r; wr_en = we;
    wr_idx = 5'(wi); wr_data = wd; rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    #1;
    exp_sp = c && !r && (mres == 4);
    exp_fl = r && !c && (mres == 1);
    chk({tag, " read A"}, rd_a_data, mdl[bmap(mptr, ra)]);
    chk({tag, " read B"}, rd_b_data, mdl[bmap(mptr, rb)]);
    chk({"R6 pointer ", tag}, 32'(win_ptr), 32'(mptr));
    chk("R9 overflow flag", 32'(spill_flag), 32'(exp_sp));
    chk("R10 underflow flag", 32'(fill_flag), 32'(exp_fl));
    @(posedge clk);
    if (we) mdl[bmap(mptr, wi)] = wd;
    if (c && !r) begin
      mptr = (mptr + 1) % 4;
      if (mres < 4) mres++;
    end else if (r && !c) begin
      mptr = (mptr + 3) % 4;
      if (mres > 1) mres--;
    end
    @(negedge clk);
    call_req = 1'b0; ret_req = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < NPH; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every logical register reads zero, pointer 0, no flags
    for (int i = 0; i < 32; i += 2) step(0, 0, 0, 0, 0, i, i + 1, "R1");

    // R2: globals unchanged across a window change
    step(0, 0, 1, 3, 32'h0000_00A5, 3, 0, "R2");
    step(1, 0, 0, 0, 0, 3, 9, "R2");
    step(0, 0, 0, 0, 0, 3, 9, "R2");
    chk("R2 global after call", rd_a_data, 32'h0000_00A5);

    // R4: caller's upper shared is callee's lower shared (window 1 -> 2)
    step(0, 0, 1, 28, 32'h1111_2222, 28, 16, "R4");
    step(1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 12, 28, "R4");
    chk("R4 param seen in callee", rd_a_data, 32'h1111_2222);

    // R8: write and call in the same cycle, write uses the old window (2 -> 3)
    step(1, 0, 1, 27, 32'h3333_4444, 27, 11, "R8");
    step(0, 0, 0, 0, 0, 11, 27, "R8");
    chk("R8 write mapped via old pointer", rd_a_data, 32'h3333_4444);

    // R5 and R9: window 3 upper shared wraps to window 0; call while full
    step(1, 0, 1, 30, 32'h5555_6666, 30, 14, "R9");
    step(0, 0, 0, 0, 0, 14, 30, "R5");
    chk("R5 ring wrap phys 14", rd_a_data, 32'h5555_6666);
    chk("R9 pointer still moved", 32'(win_ptr), 32'd0);

    // R7: call and return together change nothing
    step(1, 1, 0, 0, 0, 14, 20, "R7");
    step(0, 0, 0, 0, 0, 14, 20, "R7");
    chk("R7 pointer held", 32'(win_ptr), 32'd0);

    // R10: drain to one resident window, then return once more
    for (int k = 0; k < 4; k++) step(0, 1, 0, 0, 0, 12, 26, "R10");
    chk("R10 pointer still moved", 32'(win_ptr), 32'd0);

    // R11: both ports on the same register
    step(0, 0, 1, 20, 32'hDEAD_BEEF, 20, 20, "R11");
    step(0, 0, 0, 0, 0, 20, 20, "R11");
    chk("R11 ports agree", rd_a_data, rd_b_data);

    // R3: random traffic
    for (int n = 0; n < 4000; n++) begin
      int op = int'($urandom_range(0, 9));
      step(op == 0 || op == 2, op == 1 || op == 2, $urandom_range(0, 1) == 1,
           int'($urandom_range(0, 31)), $urandom(),
           int'($urandom_range(0, 31)), int'($urandom_range(0, 31)), "R3");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule